// File: doc/BRIEF.md
# Three-Level Encoded Threshold Gate with Wavefront Monitor

This block is a composite gate for null-convention style logic. Each of its N logical inputs is a pair of wires. Each wire is either NULL (logic 0) or DATA (logic 1). A pair with both wires at DATA means DATA, a pair with both at NULL means NULL, and a pair with only one wire at DATA means INTERMEDIATE, whichever wire that is.

The output is also a pair of wires, formed from two threshold functions without hysteresis that look at all 2N input wires:

- The low output wire is a threshold-1 function. It is DATA when any input wire is DATA.
- The high output wire is a threshold-all function. It is DATA only when every input wire is DATA.

As inputs arrive from the all-NULL state, the output moves from NULL to INTERMEDIATE to DATA. As the inputs clear, it moves back the same way.

A registered monitor samples the output pair on every clock. It reports the decoded level and pulses once for each complete DATA wavefront. It raises a sticky error when two consecutive samples jump between NULL and DATA with no INTERMEDIATE sample between them.

Top module: `enc_mid_gate`

## Requirements
- R1: `out_pair[0]` is 1 exactly when at least one bit of `in_wires` is 1, combinationally.
- R2: `out_pair[1]` is 1 exactly when every bit of `in_wires` is 1, combinationally.
- R3: `out_pair` never takes the value 2'b10 (threshold-all wire set while the threshold-1 wire is clear).
- R4: One clock after each rising edge, `level_o` shows the output sampled at that edge, decoded as follows:
  - NULL is 2'b00 (`out_pair` 2'b00).
  - INTERMEDIATE is 2'b01 (`out_pair` 2'b01).
  - DATA is 2'b11 (`out_pair` 2'b11).
- R5: `wave_done_o` is high for exactly one cycle after a sample that decodes to DATA when the previous sample did not decode to DATA.
- R6: `seq_err_o` becomes 1 after a sample that decodes to DATA when the previous sample was NULL, or to NULL when the previous sample was DATA. Once set, it stays 1 until reset.
- R7: While `rst` is high at a rising edge, the next values are `level_o` = 2'b00, `seq_err_o` = 0 and `wave_done_o` = 0. The remembered previous sample becomes NULL.
- R8: The gate has no hysteresis: the same `in_wires` value gives the same `out_pair` whether it was reached while inputs were rising or while they were falling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high monitor reset |
| in_wires | input | 2*N_IN | Input wires, two per logical input, 1 = DATA |
| out_pair | output | 2 | [0] threshold-1 wire, [1] threshold-all wire |
| level_o | output | 2 | Registered decoded output level |
| wave_done_o | output | 1 | One-cycle pulse per completed DATA wavefront |
| seq_err_o | output | 1 | Sticky illegal-progression flag |

## Verification
A wrong previous-level register shows up as an error that is missed or raised falsely on `seq_err_o`, or as a missing or doubled pulse on `wave_done_o`. Either shows one clock after the first jump or DATA arrival that follows the corruption. A fault in the threshold functions shows at once on `out_pair` for the input pattern that exposes it, and one clock later on `level_o`. The bench therefore steps through every input pattern as well as rising, falling and skipping wavefronts, and compares all outputs on every cycle.

// File: rtl/enc3_pkg.sv
package enc3_pkg;

    typedef enum logic [1:0] {
        LVL_NULL = 2'b00,
        LVL_MID  = 2'b01,
        LVL_FULL = 2'b11
    } level_e;

    typedef struct packed {
        level_e level;
        logic   done;
        logic   err;
    } mon_s;

    // pair is {threshold-all wire, threshold-1 wire}
    function automatic level_e decode_pair(input logic [1:0] pair);
        level_e lv;
        case (pair)
            2'b00:   lv = LVL_NULL;
            2'b11:   lv = LVL_FULL;
            default: lv = LVL_MID;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/enc_thresh_any.sv
module enc_thresh_any #(
    parameter int W = 4
) (
    input  logic [W-1:0] wires_i,
    output logic         hit_o
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar g = 0; g < W; g++) begin : g_or
            assign chain[g+1] = chain[g] | wires_i[g];
        end
    endgenerate

    assign hit_o = chain[W];
endmodule

// File: rtl/enc_thresh_all.sv
module enc_thresh_all #(
    parameter int W = 4
) (
    input  logic [W-1:0] wires_i,
    output logic         hit_o
);
    logic [W:0] chain;

    assign chain[0] = 1'b1;

    generate
        for (genvar g = 0; g < W; g++) begin : g_and
            assign chain[g+1] = chain[g] & wires_i[g];
        end
    endgenerate

    assign hit_o = chain[W];
endmodule

// File: rtl/enc_wave_monitor.sv
module enc_wave_monitor
    import enc3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pair_i,
    output logic [1:0] level_o,
    output logic       done_o,
    output logic       err_o
);
    mon_s   state_d, state_q;
    level_e cur_lv;
    logic   jump_up, jump_down;

    always_comb begin
        cur_lv    = decode_pair(pair_i);
        jump_up   = (state_q.level == LVL_NULL) && (cur_lv == LVL_FULL);
        jump_down = (state_q.level == LVL_FULL) && (cur_lv == LVL_NULL);
        state_d       = state_q;
        state_d.level = cur_lv;
        state_d.done  = (cur_lv == LVL_FULL) && (state_q.level != LVL_FULL);
        state_d.err   = state_q.err | jump_up | jump_down;
        if (rst) begin
            state_d.level = LVL_NULL;
            state_d.done  = 1'b0;
            state_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign level_o = state_q.level;
    assign done_o  = state_q.done;
    assign err_o   = state_q.err;
endmodule

// File: rtl/enc_mid_gate.sv
module enc_mid_gate #(
    parameter int N_IN = 2,
    localparam int WIRES = 2 * N_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIRES-1:0] in_wires,
    output logic [1:0]       out_pair,
    output logic [1:0]       level_o,
    output logic             wave_done_o,
    output logic             seq_err_o
);
    logic any_hit, all_hit;

    enc_thresh_any #(.W(WIRES)) u_any (
        .wires_i (in_wires),
        .hit_o   (any_hit)
    );

    enc_thresh_all #(.W(WIRES)) u_all (
        .wires_i (in_wires),
        .hit_o   (all_hit)
    );

    assign out_pair = {all_hit, any_hit};

    enc_wave_monitor u_mon (
        .clk     (clk),
        .rst     (rst),
        .pair_i  (out_pair),
        .level_o (level_o),
        .done_o  (wave_done_o),
        .err_o   (seq_err_o)
    );
endmodule

// File: rtl/enc_mid_gate_chk.sv
module enc_mid_gate_chk #(
    parameter int N_IN = 2,
    localparam int WIRES = 2 * N_IN
) (
    input logic             clk,
    input logic             rst,
    input logic [WIRES-1:0] in_wires,
    input logic [1:0]       out_pair,
    input logic [1:0]       level_o,
    input logic             wave_done_o,
    input logic             seq_err_o
);
    p_any_r1: assert property (@(posedge clk) disable iff (rst)
        out_pair[0] == (in_wires != '0));

    p_all_r2: assert property (@(posedge clk) disable iff (rst)
        out_pair[1] == (in_wires == '1));

    p_no_illegal_r3: assert property (@(posedge clk) disable iff (rst)
        out_pair != 2'b10);

    p_level_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> level_o == (($past(out_pair) == 2'b00) ? 2'b00 :
                             ($past(out_pair) == 2'b11) ? 2'b11 : 2'b01));

    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wave_done_o |=> !wave_done_o);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        seq_err_o |=> seq_err_o);

    p_reset_r7: assert property (@(posedge clk)
        rst |=> (level_o == 2'b00) && !seq_err_o && !wave_done_o);
endmodule

bind enc_mid_gate enc_mid_gate_chk #(.N_IN(N_IN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_wires    (in_wires),
    .out_pair    (out_pair),
    .level_o     (level_o),
    .wave_done_o (wave_done_o),
    .seq_err_o   (seq_err_o)
);

// File: tb/tb_enc_mid_gate.sv
`timescale 1ns/1ps
module tb_enc_mid_gate;
    localparam int N_IN = 2;
    localparam int W = 2 * N_IN;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_w = '0;
    logic [1:0]   out_pair, level_o;
    logic         wave_done_o, seq_err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    int m_level = 0;   // 0 NULL, 1 MID, 3 FULL
    bit m_err = 0;
    bit m_done = 0;

    enc_mid_gate #(.N_IN(N_IN)) dut (
        .clk(clk), .rst(rst), .in_wires(in_w), .out_pair(out_pair),
        .level_o(level_o), .wave_done_o(wave_done_o), .seq_err_o(seq_err_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one cycle: apply inputs, check gate, clock, check monitor
    task automatic step(input logic [W-1:0] v, input logic r);
        int ones;
        int cur;
        bit e_any, e_all;
        in_w = v;
        rst  = r;
        #1;
        ones = 0;
        for (int i = 0; i < W; i++) if (v[i]) ones++;
        e_any = (ones > 0);
        e_all = (ones == W);
        chk("R1 threshold-1 wire", out_pair[0], e_any);
        chk("R2 threshold-all wire", out_pair[1], e_all);
        chk("R3 no 10 pattern", (out_pair == 2'b10), 0);
        cur = e_all ? 3 : (e_any ? 1 : 0);
        @(posedge clk);
        if (r) begin
            m_level = 0; m_err = 0; m_done = 0;
        end else begin
            m_done = (cur == 3) && (m_level != 3);
            if ((m_level == 0 && cur == 3) || (m_level == 3 && cur == 0)) m_err = 1;
            m_level = cur;
        end
        @(negedge clk);
        if (r) begin
            chk("R7 reset level", level_o, 0);
            chk("R7 reset err", seq_err_o, 0);
            chk("R7 reset done", wave_done_o, 0);
        end else begin
            chk("R4 level", level_o, m_level);
            chk("R5 wave done", wave_done_o, m_done);
            chk("R6 seq err", seq_err_o, m_err);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [1:0] rise_pat, fall_pat;
        step(4'b0000, 1'b1);
        step(4'b0000, 1'b1);
        // R4 R5: orderly rising wavefront
        step(4'b0000, 1'b0);
        step(4'b0001, 1'b0);
        step(4'b0101, 1'b0);
        rise_pat = out_pair;
        step(4'b0111, 1'b0);
        step(4'b1111, 1'b0);
        step(4'b1111, 1'b0);
        // orderly falling wavefront
        step(4'b1101, 1'b0);
        step(4'b0101, 1'b0);
        fall_pat = out_pair;
        chk("R8 no hysteresis", fall_pat, rise_pat);
        step(4'b0100, 1'b0);
        step(4'b0000, 1'b0);
        chk("R6 no err on legal run", seq_err_o, 0);
        // second legal wavefront, different wire order
        step(4'b1000, 1'b0);
        step(4'b1111, 1'b0);
        step(4'b0010, 1'b0);
        step(4'b0000, 1'b0);
        // R6: NULL straight to DATA
        step(4'b1111, 1'b0);
        chk("R6 jump up flagged", seq_err_o, 1);
        step(4'b1110, 1'b0);
        step(4'b0000, 1'b0);
        chk("R6 sticky", seq_err_o, 1);
        // R7: reset mid-run from DATA
        step(4'b1111, 1'b0);
        step(4'b1111, 1'b1);
        // previous sample is NULL after reset: DATA now is a jump
        step(4'b1111, 1'b0);
        chk("R7 prev cleared to NULL", seq_err_o, 1);
        step(4'b1111, 1'b1);
        step(4'b1011, 1'b0);
        step(4'b1111, 1'b0);
        // R6: DATA straight to NULL
        step(4'b0000, 1'b0);
        chk("R6 jump down flagged", seq_err_o, 1);
        step(4'b0000, 1'b1);
        // every input pattern, rising then falling order
        for (int k = 0; k < 16; k++) step(k[3:0], 1'b0);
        for (int k = 15; k >= 0; k--) step(k[3:0], 1'b0);
        finish_run();
    end
endmodule